// File: doc/BRIEF.md
# Eight-Line Programmable Interrupt Controller Register File

This block is the byte-wide programming and status side of an eight-input interrupt controller. Software reaches it through two byte addresses: address 0 takes initialisation-start bytes and operation commands (end-of-interrupt, rotation, poll, read selection, special mask), and address 1 takes the remaining initialisation bytes and, once initialisation is complete, the interrupt mask. Requests arrive on eight input lines. Each line is captured as edge or level triggered according to a trigger-select register that has its own write port and a per-instance mask of writable bits.

A rotating-priority resolver chooses the winning line, and the block raises an interrupt output while that line outranks everything in service. The processor side acknowledges with a one-cycle pulse. The block presents the vector (base plus winning index, or base plus 7 when nothing wins) and updates its in-service, request and rotation state. A poll read performs the same acknowledge through the byte interface.

Top module: `pic_regfile`

## Requirements
- R1: A write to address 0 with bit 4 set clears mask, in-service, request, rotation base, vector base, read selection, poll, special mask, auto-EOI, rotate-on-auto-EOI and fully nested state, records bit 0 as "fourth byte needed" and bit 1 as single mode, and enters initialisation step 1. The trigger-select register keeps its value.
- R2: In step 1, a write to address 1 stores the vector base with its low 3 bits cleared. The next step is 2, or, in single mode, 3 when the fourth byte is needed and normal operation otherwise. From step 2 the next step is 3 when the fourth byte is needed, otherwise normal operation.
- R3: In step 3, a write to address 1 sets fully nested mode from bit 4 and auto-EOI from bit 1, then returns to normal operation. In fully nested mode an in-service bit on line 2 does not block new requests.
- R4: In normal operation, a write to address 1 loads the mask register. A read of address 1 without poll returns the mask. Masked lines never win.
- R5: An address 0 write with bit 4 clear and bit 3 set arms poll when bit 2 is set, sets the read selection from bit 0 when bit 1 is set (1 selects in-service, 0 selects request), and sets special mask mode from bit 5 when bit 6 is set. In special mask mode, masked in-service bits do not block other requests.
- R6: An address 0 write with bits 4 and 3 clear uses bits 7:5 as a command. Command 1 clears the highest-priority in-service bit. Command 5 does the same and also sets the rotation base to that index plus 1, modulo 8.
- R7: Command 3 clears in-service bit [2:0]. Command 7 clears it and sets the rotation base to [2:0]+1. Command 6 sets the rotation base to [2:0]+1. Commands 0 and 4 set rotate-on-auto-EOI from bit 7. Command 2 changes nothing.
- R8: Priority runs from the rotation base upward, modulo 8. int_o is high when the best unmasked request outranks the best in-service bit. vector_o is the vector base bits 7:3 with the winning index in bits 2:0, or 7 in bits 2:0 when nothing wins.
- R9: An ack_i pulse while a line wins, with auto-EOI off, sets that line's in-service bit and clears its request bit if the line is edge triggered.
- R10: With auto-EOI on, an acknowledge leaves the in-service register unchanged and, if rotate-on-auto-EOI is set, moves the rotation base to the index plus 1.
- R11: A level-triggered line's request bit follows its input every cycle and survives acknowledge. An edge-triggered line's request bit is set only by a low-to-high change seen against the previous sampled level.
- R12: A read while poll is armed returns 0x80 ORed with the winning index and acknowledges that line, or returns 0 when nothing wins, and disarms poll. Without poll, a read of address 0 returns the selected register.
- R13: A trigger-select write stores the data ANDed with the TRIG_WRITABLE parameter (default 0xF8). A bit set to 1 selects level triggering for that line.
- R14: When an edge-triggered line is acknowledged in the same cycle that its input rises again, the request bit stays set. When a command and an acknowledge both move the rotation base in one cycle, the command wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Byte write strobe |
| rd_en_i | input | 1 | Byte read strobe |
| addr_i | input | 1 | Byte address (0 or 1) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid while rd_en_i is high, 0 otherwise |
| trig_wr_i | input | 1 | Trigger-select write strobe |
| trig_wdata_i | input | 8 | Trigger-select write data |
| trig_o | output | 8 | Trigger-select register value |
| irq_i | input | 8 | Interrupt request lines |
| ack_i | input | 1 | One-cycle acknowledge pulse |
| int_o | output | 1 | Interrupt pending toward the processor |
| vector_o | output | 8 | Vector for the current winner |

## Verification
The sharpest same-cycle collision is an acknowledge of an edge-triggered line in the cycle where that line's input rises again. The acknowledge clears the request bit while the capture logic sets it. The bench provokes this by raising, dropping and re-raising line 2, with ack_i pulsed on the re-rise, and judges it by int_o and vector_o still naming line 2 on the next cycle and falling only after a second acknowledge. Every other cycle is also compared against a behavioural reference model that folds acknowledge, capture and command effects together in the same order.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int LINES  = 8;
  localparam int IDX_W  = $clog2(LINES);
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    ST_READY = 2'd0,
    ST_BASE  = 2'd1,
    ST_CASC  = 2'd2,
    ST_MODE  = 2'd3
  } init_st_e;

  localparam logic [2:0] CMD_RAEOI_CLR = 3'd0;
  localparam logic [2:0] CMD_NSEOI     = 3'd1;
  localparam logic [2:0] CMD_NOP       = 3'd2;
  localparam logic [2:0] CMD_SEOI      = 3'd3;
  localparam logic [2:0] CMD_RAEOI_SET = 3'd4;
  localparam logic [2:0] CMD_ROT_NSEOI = 3'd5;
  localparam logic [2:0] CMD_SET_PRIO  = 3'd6;
  localparam logic [2:0] CMD_ROT_SEOI  = 3'd7;
endpackage

// File: rtl/pic_resolver.sv
module pic_resolver #(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec_i,
  input  logic [IW-1:0] base_i,
  output logic          hit_o,
  output logic [IW-1:0] idx_o,
  output logic [IW:0]   rank_o
);
  logic [N-1:0] rot_vec;

  // rot_vec[p] is the line at priority level p
  for (genvar p = 0; p < N; p++) begin : g_rot
    logic [IW-1:0] src;
    assign src        = base_i + IW'(p);
    assign rot_vec[p] = vec_i[src];
  end

  always_comb begin
    rank_o = (IW+1)'(N);
    for (int p = N - 1; p >= 0; p--) begin
      if (rot_vec[p]) rank_o = (IW+1)'(p);
    end
  end

  assign hit_o = |vec_i;
  assign idx_o = base_i + rank_o[IW-1:0];
endmodule

// File: rtl/pic_req_capture.sv
module pic_req_capture #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] irq_i,
  input  logic [N-1:0] level_i,
  input  logic [N-1:0] clr_i,
  input  logic         flush_i,
  output logic [N-1:0] irr_o
);
  logic [N-1:0] prev_q, irr_q, rise;

  assign rise  = irq_i & ~prev_q;
  assign irr_o = irr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      irr_q  <= '0;
    end else begin
      prev_q <= irq_i;
      if (flush_i) irr_q <= '0;
      else irr_q <= (level_i & irq_i) | (~level_i & ((irr_q & ~clr_i) | rise));
    end
  end

  assert_level_follow_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flush_i |=> (((irr_q ^ $past(irq_i)) & $past(level_i)) == '0));

  assert_edge_sets_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flush_i |=> (($past(rise) & ~$past(level_i) & ~irr_q) == '0));
endmodule

// File: rtl/pic_regfile.sv
module pic_regfile
  import pic_pkg::*;
#(
  parameter logic [DATA_W-1:0] TRIG_WRITABLE = 8'hF8,
  parameter int                CASCADE_LINE  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              trig_wr_i,
  input  logic [DATA_W-1:0] trig_wdata_i,
  output logic [DATA_W-1:0] trig_o,
  input  logic [LINES-1:0]  irq_i,
  input  logic              ack_i,
  output logic              int_o,
  output logic [DATA_W-1:0] vector_o
);
  localparam logic [LINES-1:0] CASC_BIT = LINES'(1) << CASCADE_LINE;

  init_st_e          st_q;
  logic [LINES-1:0]  imr_q, isr_q, trig_q, irr;
  logic [IDX_W-1:0]  rot_q;
  logic [DATA_W-1:0] vbase_q;
  logic sel_q, poll_q, smm_q, aeoi_q, raeoi_q, sfnm_q, need4_q, single_q;

  logic             req_hit, blk_hit, eoi_hit;
  logic [IDX_W-1:0] win_idx, blk_idx, eoi_idx;
  logic [IDX_W:0]   req_rank, blk_rank, eoi_rank;
  logic [LINES-1:0] req_vec, blk_vec;
  logic             win_valid, poll_rd, ack_ev;
  logic             icw1, ocw2, ocw3;
  logic [2:0]       cmd;
  logic [IDX_W-1:0] sel_idx;
  logic [LINES-1:0] isr_clr, isr_set, cap_clr;
  logic             rot_cmd_en;
  logic [IDX_W-1:0] rot_cmd_val;

  // Resolvers: pending requests, in-service blockers, raw in-service for EOI
  assign req_vec = irr & ~imr_q;
  assign blk_vec = isr_q & (smm_q ? ~imr_q : '1) & (sfnm_q ? ~CASC_BIT : '1);

  pic_resolver #(.N(LINES), .IW(IDX_W)) u_req (
    .vec_i(req_vec), .base_i(rot_q), .hit_o(req_hit), .idx_o(win_idx), .rank_o(req_rank));
  pic_resolver #(.N(LINES), .IW(IDX_W)) u_blk (
    .vec_i(blk_vec), .base_i(rot_q), .hit_o(blk_hit), .idx_o(blk_idx), .rank_o(blk_rank));
  pic_resolver #(.N(LINES), .IW(IDX_W)) u_eoi (
    .vec_i(isr_q), .base_i(rot_q), .hit_o(eoi_hit), .idx_o(eoi_idx), .rank_o(eoi_rank));

  assign win_valid = req_hit && (req_rank < blk_rank);
  assign int_o     = win_valid;
  assign vector_o  = {vbase_q[DATA_W-1:IDX_W], win_valid ? win_idx : {IDX_W{1'b1}}};

  assign poll_rd = rd_en_i && poll_q;
  assign ack_ev  = win_valid && (ack_i || poll_rd);

  assign icw1    = wr_en_i && !addr_i && wdata_i[4];
  assign ocw3    = wr_en_i && !addr_i && !wdata_i[4] && wdata_i[3];
  assign ocw2    = wr_en_i && !addr_i && !wdata_i[4] && !wdata_i[3];
  assign cmd     = wdata_i[7:5];
  assign sel_idx = wdata_i[IDX_W-1:0];

  always_comb begin
    isr_clr     = '0;
    rot_cmd_en  = 1'b0;
    rot_cmd_val = '0;
    if (ocw2) begin
      unique case (cmd)
        CMD_NSEOI:     if (eoi_hit) isr_clr[eoi_idx] = 1'b1;
        CMD_ROT_NSEOI: if (eoi_hit) begin
          isr_clr[eoi_idx] = 1'b1;
          rot_cmd_en       = 1'b1;
          rot_cmd_val      = eoi_idx + IDX_W'(1);
        end
        CMD_SEOI:      isr_clr[sel_idx] = 1'b1;
        CMD_SET_PRIO:  begin
          rot_cmd_en  = 1'b1;
          rot_cmd_val = sel_idx + IDX_W'(1);
        end
        CMD_ROT_SEOI:  begin
          isr_clr[sel_idx] = 1'b1;
          rot_cmd_en       = 1'b1;
          rot_cmd_val      = sel_idx + IDX_W'(1);
        end
        default: ;
      endcase
    end
  end

  assign isr_set = (ack_ev && !aeoi_q) ? (LINES'(1) << win_idx) : '0;
  assign cap_clr = ack_ev ? ((LINES'(1) << win_idx) & ~trig_q) : '0;

  pic_req_capture #(.N(LINES)) u_cap (
    .clk_i(clk_i), .rst_ni(rst_ni), .irq_i(irq_i), .level_i(trig_q),
    .clr_i(cap_clr), .flush_i(icw1), .irr_o(irr));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trig_q <= '0;
    else if (trig_wr_i) trig_q <= trig_wdata_i & TRIG_WRITABLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_READY; imr_q <= '0; isr_q <= '0; rot_q <= '0; vbase_q <= '0;
      sel_q <= 1'b0; poll_q <= 1'b0; smm_q <= 1'b0; aeoi_q <= 1'b0;
      raeoi_q <= 1'b0; sfnm_q <= 1'b0; need4_q <= 1'b0; single_q <= 1'b0;
    end else if (icw1) begin
      st_q <= ST_BASE; imr_q <= '0; isr_q <= '0; rot_q <= '0; vbase_q <= '0;
      sel_q <= 1'b0; poll_q <= 1'b0; smm_q <= 1'b0; aeoi_q <= 1'b0;
      raeoi_q <= 1'b0; sfnm_q <= 1'b0;
      need4_q  <= wdata_i[0];
      single_q <= wdata_i[1];
    end else begin
      isr_q <= (isr_q & ~isr_clr) | isr_set;
      // command rotation takes precedence over auto-EOI rotation
      if (rot_cmd_en) rot_q <= rot_cmd_val;
      else if (ack_ev && aeoi_q && raeoi_q) rot_q <= win_idx + IDX_W'(1);
      if (ocw3 && wdata_i[2]) poll_q <= 1'b1;
      else if (poll_rd) poll_q <= 1'b0;
      if (ocw3 && wdata_i[1]) sel_q <= wdata_i[0];
      if (ocw3 && wdata_i[6]) smm_q <= wdata_i[5];
      if (ocw2 && (cmd == CMD_RAEOI_CLR || cmd == CMD_RAEOI_SET)) raeoi_q <= wdata_i[7];
      if (wr_en_i && addr_i) begin
        unique case (st_q)
          ST_READY: imr_q <= wdata_i;
          ST_BASE: begin
            vbase_q <= wdata_i & ~DATA_W'((1 << IDX_W) - 1);
            if (single_q) st_q <= need4_q ? ST_MODE : ST_READY;
            else st_q <= ST_CASC;
          end
          ST_CASC: st_q <= need4_q ? ST_MODE : ST_READY;
          ST_MODE: begin
            sfnm_q <= wdata_i[4];
            aeoi_q <= wdata_i[1];
            st_q   <= ST_READY;
          end
          default: st_q <= ST_READY;
        endcase
      end
    end
  end

  always_comb begin
    if (!rd_en_i) rdata_o = '0;
    else if (poll_q) rdata_o = win_valid ? {1'b1, {(DATA_W-IDX_W-1){1'b0}}, win_idx} : '0;
    else if (addr_i) rdata_o = imr_q;
    else rdata_o = sel_q ? isr_q : irr;
  end

  assign trig_o = trig_q;

  assert_icw1_restart_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    icw1 |=> (st_q == ST_BASE && imr_q == '0 && isr_q == '0 && !poll_q));

  assert_icw1_keeps_trig_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (icw1 && !trig_wr_i) |=> $stable(trig_q));

  assert_mask_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i && st_q == ST_READY) |=> imr_q == $past(wdata_i));

  assert_poll_disarm_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (poll_rd && !wr_en_i) |=> !poll_q);

  assert_ack_sets_isr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && win_valid && !aeoi_q && !wr_en_i) |=> isr_q[$past(win_idx)]);

  assert_aeoi_isr_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_ev && aeoi_q && !wr_en_i) |=> isr_q == $past(isr_q));

  assert_trig_writable_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_wr_i |=> (trig_q & ~TRIG_WRITABLE) == '0);
endmodule

// File: tb/pic_regfile_tb_top.sv
`timescale 1ns/1ps
module pic_regfile_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0, trig_wr = 1'b0, ack = 1'b0;
  logic [7:0] wdata = '0, trig_wdata = '0, irq = '0;
  logic [7:0] rdata, trig_val, vector;
  logic       int_s;

  int    n_chk = 0, n_fail = 0, cyc = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  always #4 clk = ~clk;  // 125 MHz

  pic_regfile dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .trig_wr_i(trig_wr), .trig_wdata_i(trig_wdata),
    .trig_o(trig_val), .irq_i(irq), .ack_i(ack), .int_o(int_s), .vector_o(vector));

  // ---------------- reference model ----------------
  logic [7:0] m_irr, m_isr, m_imr, m_trig, m_prev, m_vb;
  int         m_rot, m_st;
  bit         m_need4, m_single, m_aeoi, m_raeoi, m_sfnm, m_smm, m_sel, m_poll;

  function automatic int m_rank(input logic [7:0] v);
    for (int p = 0; p < 8; p++) if (v[(m_rot + p) % 8]) return p;
    return 8;
  endfunction

  function automatic int m_win();
    int rr, ri;
    logic [7:0] b;
    rr = m_rank(m_irr & ~m_imr);
    b  = m_isr;
    if (m_smm) b = b & ~m_imr;
    if (m_sfnm) b[2] = 1'b0;
    ri = m_rank(b);
    if (rr < 8 && rr < ri) return (m_rot + rr) % 8;
    return -1;
  endfunction

  function automatic logic [7:0] m_vector();
    int w = m_win();
    return {m_vb[7:3], (w >= 0) ? 3'(w) : 3'd7};
  endfunction

  function automatic logic [7:0] m_rdata();
    int w = m_win();
    if (!rd_en) return 8'h00;
    if (m_poll) return (w >= 0) ? (8'h80 | 8'(w)) : 8'h00;
    if (addr) return m_imr;
    return m_sel ? m_isr : m_irr;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_irr = '0; m_isr = '0; m_imr = '0; m_trig = '0; m_prev = '0; m_vb = '0;
      m_rot = 0; m_st = 0; m_need4 = 0; m_single = 0; m_aeoi = 0; m_raeoi = 0;
      m_sfnm = 0; m_smm = 0; m_sel = 0; m_poll = 0;
    end else begin
      int w, e, ci, rot_n;
      bit ack_ev;
      logic [7:0] nirr, clr, set;
      w      = m_win();
      ack_ev = (ack || (rd_en && m_poll)) && (w >= 0);
      if (wr_en && !addr && wdata[4]) begin
        m_irr = '0; m_isr = '0; m_imr = '0; m_vb = '0; m_rot = 0; m_st = 1;
        m_sel = 0; m_poll = 0; m_smm = 0; m_aeoi = 0; m_raeoi = 0; m_sfnm = 0;
        m_need4 = wdata[0]; m_single = wdata[1];
      end else begin
        for (int i = 0; i < 8; i++) begin
          if (m_trig[i]) nirr[i] = irq[i];
          else nirr[i] = (m_irr[i] && !(ack_ev && w == i)) || (irq[i] && !m_prev[i]);
        end
        clr = '0; set = '0; rot_n = m_rot;
        if (ack_ev) begin
          if (m_aeoi) begin
            if (m_raeoi) rot_n = (w + 1) % 8;
          end else set[w] = 1'b1;
        end
        if (rd_en && m_poll) m_poll = 0;
        if (wr_en && !addr) begin
          if (wdata[3]) begin
            if (wdata[2]) m_poll = 1;
            if (wdata[1]) m_sel = wdata[0];
            if (wdata[6]) m_smm = wdata[5];
          end else begin
            ci = int'(wdata[2:0]);
            case (int'(wdata[7:5]))
              0, 4: m_raeoi = wdata[7];
              1: begin e = m_rank(m_isr); if (e < 8) clr[(m_rot + e) % 8] = 1'b1; end
              5: begin
                e = m_rank(m_isr);
                if (e < 8) begin clr[(m_rot + e) % 8] = 1'b1; rot_n = (m_rot + e + 1) % 8; end
              end
              3: clr[ci] = 1'b1;
              6: rot_n = (ci + 1) % 8;
              7: begin clr[ci] = 1'b1; rot_n = (ci + 1) % 8; end
              default: ;
            endcase
          end
        end
        if (wr_en && addr) begin
          case (m_st)
            0: m_imr = wdata;
            1: begin m_vb = wdata & 8'hF8; m_st = m_single ? (m_need4 ? 3 : 0) : 2; end
            2: m_st = m_need4 ? 3 : 0;
            default: begin m_sfnm = wdata[4]; m_aeoi = wdata[1]; m_st = 0; end
          endcase
        end
        m_irr = nirr;
        m_isr = (m_isr & ~clr) | set;
        m_rot = rot_n;
      end
      if (trig_wr) m_trig = trig_wdata & 8'hF8;
      m_prev = irq;
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (rst_n && !done) begin
      #1;
      n_chk++;
      if (int_s !== (m_win() >= 0)) begin
        n_fail++;
        $display("FAIL %s int_o act=%0d exp=%0d t=%0t", cur_req, int_s, m_win() >= 0, $time);
      end
      n_chk++;
      if (vector !== m_vector()) begin
        n_fail++;
        $display("FAIL %s vector_o act=%h exp=%h t=%0t", cur_req, vector, m_vector(), $time);
      end
      n_chk++;
      if (trig_val !== m_trig) begin
        n_fail++;
        $display("FAIL %s trig_o act=%h exp=%h t=%0t", cur_req, trig_val, m_trig, $time);
      end
      if (rd_en) begin
        n_chk++;
        if (rdata !== m_rdata()) begin
          n_fail++;
          $display("FAIL %s rdata_o act=%h exp=%h t=%0t", cur_req, rdata, m_rdata(), $time);
        end
      end
    end
  end

  // ---------------- directed helpers (called at negedge) ----------------
  task automatic chk(input string req, input string what, input logic [7:0] act,
                     input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic bus_wr(input logic a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = 1'b0;
  endtask

  task automatic bus_rd(input logic a, input string req, input logic [7:0] exp);
    logic [7:0] q;
    rd_en = 1'b1; addr = a;
    #2 q = rdata;
    @(negedge clk);
    rd_en = 1'b0; addr = 1'b0;
    chk(req, "read", q, exp);
  endtask

  task automatic set_irq(input logic [7:0] v);
    irq = v;
    @(negedge clk);
  endtask

  task automatic pulse_ack();
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic trig_write(input logic [7:0] v);
    trig_wr = 1'b1; trig_wdata = v;
    @(negedge clk);
    trig_wr = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired act=%0d exp<=20000", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    cur_req = "R1";
    chk("R1", "reset int_o", {7'd0, int_s}, 8'h00);
    chk("R8", "reset vector_o", vector, 8'h07);
    chk("R1", "reset trig_o", trig_val, 8'h00);

    cur_req = "R13";
    trig_write(8'hFF);
    chk("R13", "trig writable mask", trig_val, 8'hF8);

    cur_req = "R2";
    bus_wr(0, 8'h10);
    bus_wr(1, 8'h27);
    bus_wr(1, 8'h55);
    bus_wr(1, 8'hFE);
    bus_rd(1, "R2", 8'hFE);
    chk("R2", "vector base low bits cleared", vector, 8'h27);

    cur_req = "R1";
    bus_wr(0, 8'h13);
    bus_wr(1, 8'h40);
    bus_wr(1, 8'h00);
    chk("R1", "trig kept over init", trig_val, 8'hF8);
    bus_rd(1, "R1", 8'h00);
    trig_write(8'h00);

    cur_req = "R11";
    set_irq(8'h20);
    chk("R11", "edge capture int_o", {7'd0, int_s}, 8'h01);
    chk("R8", "vector line 5", vector, 8'h45);
    bus_wr(0, 8'h0A);
    bus_rd(0, "R5", 8'h20);

    cur_req = "R9";
    pulse_ack();
    chk("R9", "int after ack", {7'd0, int_s}, 8'h00);
    bus_wr(0, 8'h0B);
    bus_rd(0, "R9", 8'h20);
    bus_wr(0, 8'h0A);
    bus_rd(0, "R9", 8'h00);

    cur_req = "R6";
    set_irq(8'hA4);
    chk("R8", "nested higher wins", vector, 8'h42);
    pulse_ack();
    chk("R8", "lower blocked", {7'd0, int_s}, 8'h00);
    bus_wr(0, 8'h20);
    chk("R6", "eoi line2, still blocked", {7'd0, int_s}, 8'h00);
    bus_wr(0, 8'h20);
    chk("R6", "eoi line5, line7 wins", vector, 8'h47);

    cur_req = "R7";
    pulse_ack();
    bus_wr(0, 8'h63);
    bus_wr(0, 8'h0B);
    bus_rd(0, "R7", 8'h80);
    bus_wr(0, 8'h67);
    bus_rd(0, "R7", 8'h00);
    set_irq(8'h00);
    bus_wr(0, 8'hC4);
    set_irq(8'h50);
    chk("R7", "set priority base 5", vector, 8'h46);
    pulse_ack();
    bus_wr(0, 8'hA0);
    chk("R6", "rotating eoi base 7", vector, 8'h44);
    bus_wr(0, 8'hE1);
    chk("R7", "specific rotate", vector, 8'h44);
    bus_wr(0, 8'h40);
    chk("R7", "command 2 no-op", vector, 8'h44);
    bus_rd(0, "R7", 8'h00);
    bus_wr(0, 8'h0A);
    bus_rd(0, "R7", 8'h10);

    cur_req = "R4";
    bus_wr(1, 8'h10);
    chk("R4", "masked line loses", {7'd0, int_s}, 8'h00);
    bus_rd(1, "R4", 8'h10);
    bus_wr(1, 8'h00);
    chk("R4", "unmasked line wins", vector, 8'h44);

    cur_req = "R5";
    pulse_ack();
    set_irq(8'hD0);
    chk("R8", "line7 below in-service 4", {7'd0, int_s}, 8'h00);
    bus_wr(1, 8'h10);
    bus_wr(0, 8'h68);
    chk("R5", "special mask unblocks", vector, 8'h47);
    bus_wr(0, 8'h48);
    chk("R5", "special mask off", {7'd0, int_s}, 8'h00);
    bus_wr(1, 8'h00);
    bus_wr(0, 8'h64);
    pulse_ack();
    bus_wr(0, 8'h67);

    cur_req = "R12";
    set_irq(8'h00);
    set_irq(8'h02);
    bus_wr(0, 8'h0C);
    bus_rd(0, "R12", 8'h81);
    bus_wr(0, 8'h0B);
    bus_rd(0, "R12", 8'h02);
    bus_wr(0, 8'h0C);
    bus_rd(0, "R12", 8'h00);
    bus_rd(0, "R12", 8'h02);
    bus_wr(0, 8'h61);

    cur_req = "R11";
    trig_write(8'h08);
    set_irq(8'h0A);
    chk("R11", "level line 3", vector, 8'h43);
    pulse_ack();
    bus_wr(0, 8'h0A);
    bus_rd(0, "R11", 8'h08);
    set_irq(8'h02);
    bus_rd(0, "R11", 8'h00);
    bus_wr(0, 8'h63);

    cur_req = "R10";
    set_irq(8'h00);
    bus_wr(0, 8'h13);
    bus_wr(1, 8'h40);
    bus_wr(1, 8'h02);
    chk("R1", "trig kept over second init", trig_val, 8'h08);
    bus_wr(0, 8'h80);
    set_irq(8'h40);
    chk("R10", "line 6 pending", vector, 8'h46);
    pulse_ack();
    bus_wr(0, 8'h0B);
    bus_rd(0, "R10", 8'h00);
    set_irq(8'hC1);
    chk("R10", "rotated base 7", vector, 8'h47);
    pulse_ack();
    chk("R10", "rotated base wraps to 0", vector, 8'h40);
    bus_wr(0, 8'h00);
    pulse_ack();
    set_irq(8'h00);
    set_irq(8'h81);
    chk("R10", "no rotation when flag clear", vector, 8'h40);
    pulse_ack();
    pulse_ack();
    chk("R10", "all served", {7'd0, int_s}, 8'h00);

    cur_req = "R14";
    set_irq(8'h00);
    set_irq(8'h04);
    set_irq(8'h00);
    ack = 1'b1; irq = 8'h04;
    @(negedge clk);
    ack = 1'b0;
    chk("R14", "re-rise survives ack", vector, 8'h42);
    pulse_ack();
    chk("R14", "second ack clears", {7'd0, int_s}, 8'h00);

    cur_req = "R3";
    set_irq(8'h00);
    bus_wr(0, 8'h13);
    bus_wr(1, 8'h40);
    bus_wr(1, 8'h10);
    set_irq(8'h04);
    pulse_ack();
    set_irq(8'h00);
    set_irq(8'h0C);
    chk("R3", "fully nested re-entry line 2", vector, 8'h42);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule